// File: doc/BRIEF.md
# Pin Event Interrupt Detector with De-bounce

This block watches sixteen already-synchronized input pins and turns their activity into per-pin sticky event flags and a small set of interrupt request lines. Each pin is configured independently to detect either edges or levels, and has two separate detection enables. One enable covers falling edges or a low level. The other covers rising edges or a high level. In edge mode a pin can be routed through a de-bounce filter, which accepts a new level only after two consecutive sampling points have seen it.

All pins share one control word. That word sets the de-bounce sampling period, which is 2^N ticks with N from 0 to 15. It also picks whether those ticks come from the system clock or from an external slow-clock enable pulse. A third field decides whether a pin whose enables are both clear keeps tracking its input or freezes its detection state. Software reads the flags and clears them by writing ones. Pins 0 and 1 each drive a dedicated request line, and every other pin is ORed onto one common line.

Top module: `pin_event_irq`

## Requirements
- R1: After synchronous reset, every register (de-bounce enable, trigger type, interrupt enable, flags, control) reads 0 and all interrupt request outputs are 0.
- R2: Byte offsets are: de-bounce enable 0x14 (bit n = pin n), trigger type 0x18 (bit n = pin n), interrupt enable 0x1C (bits [15:0] falling/low, bits [31:16] rising/high), flags 0x20, control 0x180 (bits [3:0] period select N, bit 4 tick source, bit 5 keep-alive). A read returns its value on rdata_o one clock after the read strobe, and unimplemented bits read 0.
- R3: With trigger type bit n = 0 (edge), the flag of pin n is set on the clock edge that first sees a high-to-low change if the falling enable is set, or a low-to-high change if the rising enable is set. A change of the other direction sets nothing.
- R4: With trigger type bit n = 1 (level), the flag is set on every clock in which the single enabled level is present, so it comes back right after a clear while that level persists.
- R5: A level-mode pin with both its falling and rising enables set never raises its flag.
- R6: Writing flag bit n as 1 clears it. Writing 0 leaves it unchanged.
- R7: If an event on pin n arrives in the same clock as a write-1 clear of flag n, the flag stays set.
- R8: With de-bounce enable bit n = 1 in edge mode, a new level counts as an edge only after two consecutive sampling points (every 2^N source ticks) see it. A pulse shorter than one period is ignored, and the flag appears later than one period after the change.
- R9: With control bit 4 = 1, the sampling period counts slow_tick_i pulses instead of clocks. With no pulses, de-bounced pins produce no events.
- R10: The de-bounce enable has no effect in level mode. A level event is flagged on the next clock even when no sampling ever happens.
- R11: irq_ded_o[0] and irq_ded_o[1] equal the flags of pins 0 and 1, and irq_common_o is the OR of the flags of pins 2 to 15. These outputs change on the same edge as the flags.
- R12: With control bit 5 = 0, a pin with both enables clear holds its edge history. Enabling it later compares against the held level. With bit 5 = 1, the history follows the input at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pins_i | input | 16 | Synchronized pin levels |
| slow_tick_i | input | 1 | Single-cycle slow-clock enable pulse |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 9 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one clock after rd_en_i |
| irq_ded_o | output | 2 | Dedicated requests for pins 0 and 1 |
| irq_common_o | output | 1 | Shared request for pins 2 to 15 |

## Verification
The bench sweeps every pin in both edge directions and checks the exact clock of the flag and of the request line it maps to. A wrong pin-to-line mapping or a reversed polarity enable would show up on the wrong output. It races a new event against a write-1 clear and a level against repeated clears, which catches a design that gives the clear priority. It feeds one-cycle glitches and held changes through the de-bounce filter with both tick sources, including a source that never ticks. A filter that takes a single sample, or that wrongly touches level mode, would flag too early or not at all. Finally it enables a pin after its input moved while idle, once with keep-alive off and once with it on: a design that ignores the keep-alive bit would produce the spurious edge in both runs or in neither.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned CTRL_W = SEL_W + 2;

  localparam logic [ADDR_W-1:0] OFS_DBNC = 9'h014;
  localparam logic [ADDR_W-1:0] OFS_TRIG = 9'h018;
  localparam logic [ADDR_W-1:0] OFS_ENAB = 9'h01C;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 9'h020;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 9'h180;

  // bit 5 keep-alive, bit 4 slow source, bits [3:0] period select
  typedef struct packed {
    logic             keep;
    logic             slow;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/pin_event_regs.sv
module pin_event_regs
  import pin_event_pkg::*;
#(
  parameter int unsigned PINS   = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PINS-1:0]   flag_q_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PINS-1:0]   dbnc_en_o,
  output logic [PINS-1:0]   trig_lvl_o,
  output logic [PINS-1:0]   fall_en_o,
  output logic [PINS-1:0]   rise_en_o,
  output ctrl_t             ctrl_o,
  output logic [PINS-1:0]   flag_clr_o
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dbnc_en_o  <= '0;
      trig_lvl_o <= '0;
      fall_en_o  <= '0;
      rise_en_o  <= '0;
      ctrl_o     <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFS_DBNC: dbnc_en_o  <= wdata_i[PINS-1:0];
        OFS_TRIG: trig_lvl_o <= wdata_i[PINS-1:0];
        OFS_ENAB: begin
          fall_en_o <= wdata_i[PINS-1:0];
          rise_en_o <= wdata_i[HALF +: PINS];
        end
        OFS_CTRL: ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  assign flag_clr_o = (wr_en_i && addr_i == OFS_FLAG) ? wdata_i[PINS-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFS_DBNC: rd_mux[PINS-1:0] = dbnc_en_o;
      OFS_TRIG: rd_mux[PINS-1:0] = trig_lvl_o;
      OFS_ENAB: begin
        rd_mux[PINS-1:0]    = fall_en_o;
        rd_mux[HALF +: PINS] = rise_en_o;
      end
      OFS_FLAG: rd_mux[PINS-1:0] = flag_q_i;
      OFS_CTRL: rd_mux[CTRL_W-1:0] = ctrl_o;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/pin_event_prescale.sv
module pin_event_prescale
  import pin_event_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic slow_tick_i,
  input  ctrl_t ctrl_i,
  output logic strobe_o
);
  localparam int unsigned CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic             src_tick;
  logic             hit;

  assign term     = (CNT_W'(1) << ctrl_i.sel) - CNT_W'(1);
  assign src_tick = ctrl_i.slow ? slow_tick_i : 1'b1;
  assign hit      = src_tick && (cnt_q >= term);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q    <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= hit;
      if (src_tick) cnt_q <= hit ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pin_event_cell.sv
module pin_event_cell (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pin_i,
  input  logic strobe_i,
  input  logic keep_i,
  input  logic dbnc_i,
  input  logic lvl_i,
  input  logic fall_i,
  input  logic rise_i,
  input  logic clr_i,
  output logic flag_q_o,
  output logic flag_d_o
);
  logic active;
  logic smp_q;
  logic stab_q;
  logic prev_q;
  logic cur;
  logic edge_evt;
  logic lvl_evt;

  assign active = keep_i | fall_i | rise_i;
  assign cur    = dbnc_i ? stab_q : pin_i;

  // two matching samples in a row are needed before the filtered level moves
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      smp_q  <= 1'b0;
      stab_q <= 1'b0;
    end else if (active && strobe_i) begin
      smp_q <= pin_i;
      if (pin_i == smp_q) stab_q <= pin_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       prev_q <= 1'b0;
    else if (active) prev_q <= cur;
  end

  assign edge_evt = ~lvl_i & ((fall_i & prev_q & ~cur) | (rise_i & ~prev_q & cur));
  assign lvl_evt  = lvl_i & (fall_i ^ rise_i) & (fall_i ? ~pin_i : pin_i);
  assign flag_d_o = edge_evt | lvl_evt | (flag_q_o & ~clr_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) flag_q_o <= 1'b0;
    else       flag_q_o <= flag_d_o;
  end
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pin_event_pkg::*;
#(
  parameter int unsigned PINS    = 16,
  parameter int unsigned NUM_DED = 2,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [PINS-1:0]    pins_i,
  input  logic               slow_tick_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_DED-1:0] irq_ded_o,
  output logic               irq_common_o
);
  logic [PINS-1:0] dbnc_en;
  logic [PINS-1:0] trig_lvl;
  logic [PINS-1:0] fall_en;
  logic [PINS-1:0] rise_en;
  logic [PINS-1:0] flag_clr;
  logic [PINS-1:0] flag_q;
  logic [PINS-1:0] flag_d;
  ctrl_t           ctrl;
  logic            strobe;

  pin_event_regs #(.PINS(PINS), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .flag_q_i   (flag_q),
    .rdata_o    (rdata_o),
    .dbnc_en_o  (dbnc_en),
    .trig_lvl_o (trig_lvl),
    .fall_en_o  (fall_en),
    .rise_en_o  (rise_en),
    .ctrl_o     (ctrl),
    .flag_clr_o (flag_clr)
  );

  pin_event_prescale u_prescale (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .slow_tick_i (slow_tick_i),
    .ctrl_i      (ctrl),
    .strobe_o    (strobe)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_cell
    pin_event_cell u_cell (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .pin_i    (pins_i[i]),
      .strobe_i (strobe),
      .keep_i   (ctrl.keep),
      .dbnc_i   (dbnc_en[i]),
      .lvl_i    (trig_lvl[i]),
      .fall_i   (fall_en[i]),
      .rise_i   (rise_en[i]),
      .clr_i    (flag_clr[i]),
      .flag_q_o (flag_q[i]),
      .flag_d_o (flag_d[i])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_ded_o    <= '0;
      irq_common_o <= 1'b0;
    end else begin
      irq_ded_o    <= flag_d[NUM_DED-1:0];
      irq_common_o <= |flag_d[PINS-1:NUM_DED];
    end
  end
endmodule

// File: rtl/pin_event_irq_chk.sv
module pin_event_irq_chk
  import pin_event_pkg::*;
#(
  parameter int unsigned PINS    = 16,
  parameter int unsigned NUM_DED = 2
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [PINS-1:0]    wdata_lo,
  input logic [PINS-1:0]    flags,
  input logic [PINS-1:0]    fall_en,
  input logic [PINS-1:0]    rise_en,
  input logic [PINS-1:0]    trig_lvl,
  input logic [NUM_DED-1:0] irq_ded,
  input logic               irq_common
);
  logic [PINS-1:0] w1c_mask;
  assign w1c_mask = (wr_en_i && addr_i == OFS_FLAG) ? wdata_lo : '0;

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> (flags == '0 && irq_common == 1'b0 && irq_ded == '0));

  // R11
  irq_line_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_ded == flags[NUM_DED-1:0]) && (irq_common == |flags[PINS-1:NUM_DED]));

  // R3
  flag_source_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (flags & ~$past(flags) & ~$past(fall_en | rise_en)) == '0);

  // R5
  level_both_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (flags & ~$past(flags) & $past(trig_lvl & fall_en & rise_en)) == '0);

  // R6
  clear_only_w1c_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(flags) & ~flags & ~$past(w1c_mask)) == '0);
endmodule

bind pin_event_irq pin_event_irq_chk #(.PINS(PINS), .NUM_DED(NUM_DED)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_lo   (wdata_i[PINS-1:0]),
  .flags      (flag_q),
  .fall_en    (fall_en),
  .rise_en    (rise_en),
  .trig_lvl   (trig_lvl),
  .irq_ded    (irq_ded_o),
  .irq_common (irq_common_o)
);

// File: tb/test_pin_event_irq.sv
module test_pin_event_irq;
  localparam logic [8:0] A_DBNC = 9'h014;
  localparam logic [8:0] A_TRIG = 9'h018;
  localparam logic [8:0] A_ENAB = 9'h01C;
  localparam logic [8:0] A_FLAG = 9'h020;
  localparam logic [8:0] A_CTRL = 9'h180;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pins = '0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq_ded;
  logic        irq_com;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_event_irq i_pin_event_irq (
    .clk_i(clk), .rst_i(rst), .pins_i(pins), .slow_tick_i(tick),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_ded_o(irq_ded), .irq_common_o(irq_com)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic chk_reg(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic chk_irq(input string req, input logic [15:0] fl);
    chk({req, " ded"}, {30'd0, irq_ded}, {30'd0, fl[1:0]});
    chk({req, " common"}, {31'd0, irq_com}, {31'd0, |fl[15:2]});
  endtask

  task automatic clean();
    wr(A_ENAB, 32'h0);
    wr(A_TRIG, 32'h0);
    wr(A_DBNC, 32'h0);
    wr(A_FLAG, 32'hFFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk_irq("R1", 16'h0);
    chk_reg("R1 dbnc", A_DBNC, 0);
    chk_reg("R1 trig", A_TRIG, 0);
    chk_reg("R1 enab", A_ENAB, 0);
    chk_reg("R1 flag", A_FLAG, 0);
    chk_reg("R1 ctrl", A_CTRL, 0);

    // R2 readback and unused bits
    wr(A_DBNC, 32'hFFFF_A5C3);
    wr(A_TRIG, 32'h0000_5A3C);
    wr(A_ENAB, 32'h1234_ABCD);
    wr(A_CTRL, 32'hFFFF_FFFF);
    chk_reg("R2 dbnc", A_DBNC, 32'h0000_A5C3);
    chk_reg("R2 trig", A_TRIG, 32'h0000_5A3C);
    chk_reg("R2 enab", A_ENAB, 32'h1234_ABCD);
    chk_reg("R2 ctrl", A_CTRL, 32'h0000_003F);
    chk_reg("R2 unmapped", 9'h024, 32'h0);
    wr(A_CTRL, 32'h20);
    clean();
    chk_reg("R2 flag cleared", A_FLAG, 0);

    // R3 / R11 sweep over all pins, both edge directions
    for (int n = 0; n < 16; n++) begin
      logic [15:0] b;
      b = 16'h1 << n;
      wr(A_ENAB, {16'h0, b});
      pins[n] = 1'b1; step();
      chk_irq($sformatf("R3 pin%0d rise ignored", n), 16'h0);
      pins[n] = 1'b0; step();
      chk_irq($sformatf("R11 pin%0d fall", n), b);
      chk_reg($sformatf("R3 pin%0d fall flag", n), A_FLAG, {16'h0, b});
      wr(A_FLAG, 32'hFFFF);
      wr(A_ENAB, {b, 16'h0});
      pins[n] = 1'b1; step();
      chk_irq($sformatf("R11 pin%0d rise", n), b);
      wr(A_FLAG, 32'hFFFF);
      pins[n] = 1'b0; step();
      chk_irq($sformatf("R3 pin%0d fall ignored", n), 16'h0);
    end
    clean();

    // R6 write-1-to-clear
    wr(A_ENAB, 32'h0000_0024);
    pins[2] = 1'b1; pins[5] = 1'b1; step();
    pins[2] = 1'b0; pins[5] = 1'b0; step();
    chk_reg("R6 two flags", A_FLAG, 32'h24);
    wr(A_FLAG, 32'h0);
    chk_reg("R6 write 0 no effect", A_FLAG, 32'h24);
    wr(A_FLAG, 32'h4);
    chk_reg("R6 clear one bit", A_FLAG, 32'h20);
    wr(A_FLAG, 32'h20);
    chk_reg("R6 clear last bit", A_FLAG, 32'h0);

    // R7 edge event racing a clear
    wr(A_ENAB, 32'h0000_0004);
    pins[2] = 1'b1; step();
    pins[2] = 1'b0; step();
    pins[2] = 1'b1; step();
    @(negedge clk);
    wr_en = 1'b1; addr = A_FLAG; wdata = 32'h4; pins[2] = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    chk_irq("R7 event beats clear", 16'h4);
    chk_reg("R7 flag kept", A_FLAG, 32'h4);
    clean();

    // R4 level low on pin 3, with R7 against repeated clears
    wr(A_TRIG, 32'h8);
    wr(A_ENAB, 32'h8);
    step();
    chk_reg("R4 level flag", A_FLAG, 32'h8);
    wr(A_FLAG, 32'h8);
    chk_reg("R4 level persists after clear", A_FLAG, 32'h8);
    pins[3] = 1'b1; step();
    wr(A_FLAG, 32'h8);
    chk_reg("R4 level gone", A_FLAG, 32'h0);
    pins[3] = 1'b0; step();
    chk_irq("R4 level returns", 16'h8);
    clean();
    pins[3] = 1'b0;

    // R5 level with both polarities
    wr(A_TRIG, 32'h80);
    wr(A_ENAB, 32'h0080_0080);
    step(3);
    chk_reg("R5 both low", A_FLAG, 32'h0);
    pins[7] = 1'b1; step(3);
    chk_reg("R5 both high", A_FLAG, 32'h0);
    pins[7] = 1'b0; step(2);
    chk_irq("R5 no request", 16'h0);
    clean();

    // R10 de-bounce ignored in level mode (slow source, no ticks)
    wr(A_CTRL, 32'h30);
    wr(A_DBNC, 32'h10);
    wr(A_TRIG, 32'h10);
    wr(A_ENAB, 32'h0010_0000);
    pins[4] = 1'b1; step();
    chk_irq("R10 level flag despite de-bounce", 16'h10);
    clean();
    pins[4] = 1'b0;

    // R8 de-bounce, system clock, period 4
    wr(A_CTRL, 32'h22);
    wr(A_DBNC, 32'h40);
    wr(A_ENAB, 32'h0040_0000);
    step(10);
    pins[6] = 1'b1; step();
    pins[6] = 1'b0; step(20);
    chk_reg("R8 glitch ignored", A_FLAG, 32'h0);
    @(negedge clk);
    pins[6] = 1'b1;
    step(4);
    chk_irq("R8 not before one period", 16'h0);
    step(5);
    chk_irq("R8 accepted after two samples", 16'h40);
    clean();
    pins[6] = 1'b0;

    // R9 slow tick source, period 1 tick
    wr(A_CTRL, 32'h30);
    wr(A_DBNC, 32'h200);
    wr(A_ENAB, 32'h0200_0000);
    step(3);
    pins[9] = 1'b1; step(30);
    chk_irq("R9 no ticks no event", 16'h0);
    tick = 1'b1; step(); tick = 1'b0; step(4);
    chk_irq("R9 one tick not enough", 16'h0);
    tick = 1'b1; step(); tick = 1'b0; step(4);
    chk_irq("R9 second tick accepts", 16'h200);
    clean();
    pins[9] = 1'b0;

    // R12 keep-alive off: history frozen while pin disabled
    wr(A_CTRL, 32'h00);
    step(2);
    pins[10] = 1'b1; step(3);
    wr(A_ENAB, 32'h0400_0000);
    step();
    chk_irq("R12 held history gives edge", 16'h400);
    clean();
    // R12 keep-alive on: history tracks, no edge on enable
    wr(A_CTRL, 32'h20);
    pins[10] = 1'b0; step(3);
    pins[10] = 1'b1; step(3);
    wr(A_ENAB, 32'h0400_0000);
    step(2);
    chk_irq("R12 tracked history no edge", 16'h0);
    clean();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule